// File: doc/BRIEF.md
# Write-One-to-Set Command Status Register

This block holds the command and status word that a host controller shares with its software driver. Software writes it as a set-only register: a 1 in any written bit position sets that command bit, and a 0 leaves the bit as it was. The driver can therefore post several independent commands in separate writes without having to read the word first, and without disturbing commands that are still pending. Only the hardware clears a command bit. It does so through a dedicated clear input per bit, which is how it acknowledges that the command has been carried out.

Four command bits occupy the low nibble: a controller reset request, a control-list-filled flag, a bulk-list-filled flag and an ownership-change request.

A 2-bit counter in bits 17:16 counts the frames in which the periodic schedule failed to finish before the end of the frame. Software can read this counter but cannot write it. Each overrun event increments the counter. In the same cycle as the increment, the block raises a one-cycle pulse that sets the overrun flag in the separate interrupt-status register.

Top module: `cmd_stat_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x0000_0000 and `ovr_irq_set` is 0.
- R2: A write with `wr_en` high sets each command bit 3:0 whose `wr_data` bit is 1. The bits are 0 = reset request, 1 = control-list-filled, 2 = bulk-list-filled and 3 = ownership-change. The new value is visible on `rd_data` from the cycle after the write edge.
- R3: A command bit written as 0 keeps its value, so successive writes accumulate their set bits.
- R4: A high `hw_clr[k]` clears command bit k on the next edge. This is also how a pending reset request (bit 0) self-clears when the hardware acknowledges that the reset has completed.
- R5: If `hw_clr[k]` and a software write of 1 to bit k arrive in the same cycle, the bit ends up set.
- R6: Reserved bits 15:4 and 31:18 always read 0, even after a write of all ones.
- R7: The overrun counter in bits 17:16 ignores software writes, and it holds its value in every cycle without `ovr_evt`.
- R8: Each cycle with `ovr_evt` high increments the counter in bits 17:16 by one, visible from the next cycle.
- R9: The counter wraps from 3 to 0 on the next overrun.
- R10: `ovr_irq_set` is high for exactly one cycle per overrun event, in the same cycle that the incremented counter first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data, set-only semantics |
| rd_data | output | 32 | Current register value |
| hw_clr | input | 4 | Per-command-bit hardware clear |
| ovr_evt | input | 1 | Scheduling-overrun detected this cycle |
| ovr_irq_set | output | 1 | One-cycle pulse that sets the overrun interrupt-status flag |

## Verification
Every state bit is readable, so a corrupted command bit or counter value shows up on `rd_data` in the cycle after the faulty edge. The bench compares the full word after every stimulus step. A set lost to a hardware clear, a reserved bit leaking through, or a counter that saturates instead of wrapping each shows as a wrong word one cycle after the stimulus. A late or stretched interrupt pulse shows as a mismatch between `ovr_irq_set` and the counter change in that same sampled cycle.

// File: rtl/cmd_stat_pkg.sv
package cmd_stat_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CMD_N   = 4;
  localparam int unsigned OVR_W   = 2;
  localparam int unsigned OVR_LSB = 16;
  localparam int unsigned OVR_MSB = OVR_LSB + OVR_W - 1;

  // Command bit positions; the driver decodes these positions.
  localparam int unsigned BIT_RST_REQ = 0;
  localparam int unsigned BIT_CTL_FIL = 1;
  localparam int unsigned BIT_BLK_FIL = 2;
  localparam int unsigned BIT_OWN_CHG = 3;
endpackage

// File: rtl/cmd_bit_cell.sv
module cmd_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_nxt;

  // A set beats a clear in the same cycle.
  always_comb begin
    q_nxt = q_o;
    if (clr_i) q_nxt = 1'b0;
    if (set_i) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/ovr_counter.sv
module ovr_counter #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  output logic [W-1:0] cnt_o,
  output logic         pulse_o
);
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  assign cnt_en  = evt_i;
  assign cnt_nxt = cnt_o + W'(1);   // natural wrap at the top value

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (cnt_en) cnt_o <= cnt_nxt;
  end

  // The pulse is registered so it appears together with the new count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= evt_i;
  end
endmodule

// File: rtl/cmd_stat_reg.sv
module cmd_stat_reg
  import cmd_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CMD_N-1:0]  hw_clr,
  input  logic              ovr_evt,
  output logic              ovr_irq_set
);
  logic [CMD_N-1:0] cmd_q;
  logic [CMD_N-1:0] cmd_set;
  logic [OVR_W-1:0] ovr_cnt;

  assign cmd_set = {CMD_N{wr_en}} & wr_data[CMD_N-1:0];

  for (genvar g = 0; g < CMD_N; g++) begin : g_cmd
    cmd_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cmd_set[g]),
      .clr_i (hw_clr[g]),
      .q_o   (cmd_q[g])
    );
  end

  ovr_counter #(.W(OVR_W)) u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (ovr_evt),
    .cnt_o   (ovr_cnt),
    .pulse_o (ovr_irq_set)
  );

  // Read word: reserved positions are tied to 0.
  always_comb begin
    rd_data                  = '0;
    rd_data[CMD_N-1:0]       = cmd_q;
    rd_data[OVR_MSB:OVR_LSB] = ovr_cnt;
  end
endmodule

// File: rtl/cmd_stat_reg_chk.sv
module cmd_stat_reg_chk
  import cmd_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [CMD_N-1:0]  hw_clr,
  input logic              ovr_evt,
  input logic              ovr_irq_set
);
  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'((1 << CMD_N) - 1)) | (DATA_W'((1 << OVR_W) - 1) << OVR_LSB);

  // R2: written ones are set on the next cycle
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data[CMD_N-1:0] & $past(wr_data[CMD_N-1:0])) == $past(wr_data[CMD_N-1:0])));

  // R3: without a hardware clear no command bit drops
  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr == '0) |=> ((rd_data[CMD_N-1:0] & $past(rd_data[CMD_N-1:0])) == $past(rd_data[CMD_N-1:0])));

  // R4 and R5: a clear without a competing set empties the bit
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_clr & ~({CMD_N{wr_en}} & wr_data[CMD_N-1:0]))) |=>
      ((rd_data[CMD_N-1:0] & $past(hw_clr & ~({CMD_N{wr_en}} & wr_data[CMD_N-1:0]))) == '0));

  // R6: reserved bits stay 0
  p_resv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == '0);

  // R7: counter holds without an event
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_evt |=> $stable(rd_data[OVR_MSB:OVR_LSB]));

  // R8 and R9: counter steps by one, wrapping
  p_cnt_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (rd_data[OVR_MSB:OVR_LSB] == OVR_W'($past(rd_data[OVR_MSB:OVR_LSB]) + OVR_W'(1))));

  // R10: pulse tracks the event one cycle later, and only then
  p_irq_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_irq_set);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_evt |=> !ovr_irq_set);
endmodule

bind cmd_stat_reg cmd_stat_reg_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .hw_clr      (hw_clr),
  .ovr_evt     (ovr_evt),
  .ovr_irq_set (ovr_irq_set)
);

// File: tb/cmd_stat_reg_tb_top.sv
module cmd_stat_reg_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  hw_clr;
  logic        ovr_evt;
  logic        ovr_irq_set;

  int n_cmp;
  int n_bad;
  bit done;

  typedef struct packed {
    logic        wr;
    logic [31:0] d;
    logic [3:0]  clr;
    logic        evt;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_0002, 4'h0, 1'b0, 32'h0000_0002, 1'b0}, // R2
    '{1'b1, 32'h0000_0004, 4'h0, 1'b0, 32'h0000_0006, 1'b0}, // R3 accumulate
    '{1'b1, 32'h0000_0000, 4'h0, 1'b0, 32'h0000_0006, 1'b0}, // R3 zero write
    '{1'b1, 32'hFFFF_FFF0, 4'h0, 1'b0, 32'h0000_0006, 1'b0}, // R6, R7
    '{1'b0, 32'h0000_0000, 4'h0, 1'b1, 32'h0001_0006, 1'b1}, // R8, R10
    '{1'b0, 32'h0000_0000, 4'h0, 1'b0, 32'h0001_0006, 1'b0}, // R10 one cycle
    '{1'b0, 32'h0000_0000, 4'h2, 1'b0, 32'h0001_0004, 1'b0}, // R4
    '{1'b1, 32'h0000_0002, 4'h2, 1'b0, 32'h0001_0006, 1'b0}, // R5
    '{1'b1, 32'h0000_0009, 4'h0, 1'b1, 32'h0002_000F, 1'b1}, // R2, R8
    '{1'b0, 32'h0000_0000, 4'h0, 1'b1, 32'h0003_000F, 1'b1}, // R8
    '{1'b0, 32'h0000_0000, 4'h0, 1'b1, 32'h0000_000F, 1'b1}, // R9 wrap
    '{1'b0, 32'h0000_0000, 4'hE, 1'b0, 32'h0000_0001, 1'b0}, // R4
    '{1'b1, 32'hFFFF_FFFF, 4'h0, 1'b0, 32'h0000_000F, 1'b0}, // R6, R7
    '{1'b0, 32'h0000_0000, 4'h1, 1'b0, 32'h0000_000E, 1'b0}  // R4 reset ack
  };

  function automatic string tag_of(input int i);
    case (i)
      0:       return "R2";
      1, 2:    return "R3";
      3, 12:   return "R6";
      4, 9:    return "R8";
      5:       return "R10";
      6, 11, 13: return "R4";
      7:       return "R5";
      8:       return "R2";
      10:      return "R9";
      default: return "R7";
    endcase
  endfunction

  cmd_stat_reg dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .hw_clr      (hw_clr),
    .ovr_evt     (ovr_evt),
    .ovr_irq_set (ovr_irq_set)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ovr_irq_set got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    wr_en = 1'b0; wr_data = '0; hw_clr = '0; ovr_evt = 1'b0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check32("R1", rd_data, 32'h0);
    check1("R1", ovr_irq_set, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check32("R1", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wr; wr_data = VEC[i].d; hw_clr = VEC[i].clr; ovr_evt = VEC[i].evt;
      @(negedge clk);
      check32(tag_of(i), rd_data, VEC[i].exp_rd);
      check1(tag_of(i), ovr_irq_set, VEC[i].exp_irq);
    end
    drive_idle();

    // R7: idle cycles leave the counter and bits alone
    repeat (3) @(negedge clk);
    check32("R7", rd_data, 32'h0000_000E);

    // R8: two events back to back, then R10 pulse must fall
    ovr_evt = 1'b1;
    @(negedge clk);
    check32("R8", rd_data, 32'h0001_000E);
    @(negedge clk);
    check32("R8", rd_data, 32'h0002_000E);
    check1("R10", ovr_irq_set, 1'b1);
    ovr_evt = 1'b0;
    @(negedge clk);
    check1("R10", ovr_irq_set, 1'b0);

    // R1: asynchronous reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    check32("R1", rd_data, 32'h0);
    check1("R1", ovr_irq_set, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check32("R1", rd_data, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule